// File: doc/BRIEF.md
# Converter Enable and Mute Sequencer

This block sequences the start-up and muting of one sample rate converter channel. A software-written control word carries an enable bit. Once that bit has settled at a new level, the sequencer acts on it. A rising level enables the channel's output pins. It also starts a sweep that writes zero into every location of the channel's sample FIFO. When the sweep completes, the channel waits in a muted state until the rate tracking loop reports that it has moved from fast settling to slow settling. Only then is the mute-out flag raised.

A single-cycle rate-change pulse from the ratio detector drops the flag again. The flag stays low until slow settling is reported anew. A falling enable level turns the outputs off, lowers mute-out and abandons any sweep in progress. Whenever mute-out is low, the block asks the downstream sample path to force zero samples.

The FIFO clearing writes leave the block on a valid/ready stream. The address and the zero data are held steady while ready is low. The address advances only on a cycle where valid and ready are both high. The FIFO side may stall the sweep for any number of cycles. Every other pin is a plain level or pulse.

Top module: `conv_mute_seq`

## Requirements
- R1: While reset is applied and just after it, out_en, mute_out, busy and fifo_wr_valid are 0 and path_mute is 1.
- R2: Only bit EN_BIT (bit 31 by default) of ctrl_word controls the sequencer. All other bits of the word have no effect.
- R3: A new level of the enable bit takes effect only after it has differed from the current level on FILT_CYC (default 5) consecutive clock edges. A pulse shorter than that changes nothing.
- R4: One edge after the enable level is accepted as 1, out_en and busy go to 1, mute_out stays 0, and the sweep presents address 0.
- R5: During the sweep, fifo_wr_valid is 1 and fifo_wr_data is 0. The addresses run from 0 up to DEPTH-1, one per accepted handshake. While fifo_wr_ready is 0, the address holds.
- R6: busy and fifo_wr_valid return to 0 on the edge that accepts the write to address DEPTH-1.
- R7: After the sweep, mute_out stays 0 while slow_settle is 0. mute_out becomes 1 on the first edge at which slow_settle is 1 and rate_change is 0.
- R8: A rate_change pulse clears mute_out on the next edge. A rate_change pulse while mute_out is already 0 keeps it at 0.
- R9: One edge after the enable level is accepted as 0, out_en, mute_out, busy and fifo_wr_valid are 0, which aborts a sweep in progress. A later enable starts the sweep again from address 0.
- R10: path_mute is 1 in every cycle in which mute_out is 0, and 0 while mute_out is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_word | input | CTRL_W | Channel control word; bit EN_BIT is the enable |
| rate_change | input | 1 | Single-cycle pulse on a detected sample rate ratio change |
| slow_settle | input | 1 | 1 while the tracking loop is in slow settling |
| fifo_wr_valid | output | 1 | Clearing write is offered |
| fifo_wr_ready | input | 1 | FIFO accepts the clearing write |
| fifo_wr_addr | output | $clog2(DEPTH) | FIFO location being cleared |
| fifo_wr_data | output | DATA_W | Write data, always zero |
| busy | output | 1 | Clearing sweep in progress |
| mute_out | output | 1 | 1 once the channel has settled and may play |
| out_en | output | 1 | Output pin enable |
| path_mute | output | 1 | Forces downstream samples to zero |

## Verification
The bench builds the block with DEPTH=4, DATA_W=8 and the default FILT_CYC=5. A four-entry FIFO makes a full sweep only four handshakes long. Within a few vectors the bench can therefore reach a sweep that stalls, an abort part-way through at a nonzero address, a restart from address 0 and a sweep that finishes. Keeping the filter at five edges puts four-edge pulses of either polarity just below the acceptance threshold. That shows the filter boundary on both the set and the clear side.

// File: rtl/conv_mute_seq_pkg.sv
package conv_mute_seq_pkg;

  // Sequencer phases
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_SWEEP = 2'd1,
    ST_MUTED = 2'd2,
    ST_RUN   = 2'd3
  } seq_state_e;

endpackage

// File: rtl/seq_en_filter.sv
// Accepts a new enable level only after it has persisted for FILT_CYC edges.
module seq_en_filter #(
  parameter int FILT_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);

  generate
    if (FILT_CYC <= 1) begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) filt <= 1'b0;
        else        filt <= raw;
      end
    end else begin : g_count
      localparam int CNT_W = $clog2(FILT_CYC);
      localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_CYC - 1);
      logic [CNT_W-1:0] run_cnt;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          filt    <= 1'b0;
          run_cnt <= '0;
        end else if (raw == filt) begin
          run_cnt <= '0;
        end else if (run_cnt == CNT_LAST) begin
          filt    <= raw;
          run_cnt <= '0;
        end else begin
          run_cnt <= run_cnt + 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/seq_clear_sweep.sv
// Walks the FIFO address space once, offering a zero write per location.
module seq_clear_sweep #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 24,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              active,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              done
);

  localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] addr_q;
  logic              accept;
  logic              at_last;

  assign accept   = active && wr_ready;
  assign at_last  = (addr_q == ADDR_LAST);
  assign done     = accept && at_last;
  assign wr_valid = active;
  assign wr_addr  = addr_q;
  assign wr_data  = '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (clr) begin
      addr_q <= '0;
    end else if (accept) begin
      addr_q <= at_last ? '0 : addr_q + 1'b1;
    end
  end

endmodule

// File: rtl/seq_mute_fsm.sv
// Phase controller: off, clearing sweep, muted wait, running.
module seq_mute_fsm
  import conv_mute_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_f,
  input  logic       sweep_done,
  input  logic       slow_settle,
  input  logic       rate_change,
  output seq_state_e state,
  output logic       sweep_clr,
  output logic       sweep_active
);

  seq_state_e state_d;

  always_comb begin
    state_d = state;
    if (!en_f) begin
      state_d = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF:   state_d = ST_SWEEP;
        ST_SWEEP: if (sweep_done) state_d = ST_MUTED;
        ST_MUTED: if (slow_settle && !rate_change) state_d = ST_RUN;
        ST_RUN:   if (rate_change) state_d = ST_MUTED;
        default:  state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_OFF;
    else        state <= state_d;
  end

  assign sweep_clr    = (state == ST_OFF);
  assign sweep_active = (state == ST_SWEEP);

endmodule

// File: rtl/conv_mute_seq.sv
module conv_mute_seq
  import conv_mute_seq_pkg::*;
#(
  parameter int CTRL_W   = 32,
  parameter int EN_BIT   = 31,
  parameter int DEPTH    = 64,
  parameter int DATA_W   = 24,
  parameter int FILT_CYC = 5,
  localparam int ADDR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic              rate_change,
  input  logic              slow_settle,
  output logic              fifo_wr_valid,
  input  logic              fifo_wr_ready,
  output logic [ADDR_W-1:0] fifo_wr_addr,
  output logic [DATA_W-1:0] fifo_wr_data,
  output logic              busy,
  output logic              mute_out,
  output logic              out_en,
  output logic              path_mute
);

  logic       en_f;
  logic       sweep_done;
  logic       sweep_clr;
  logic       sweep_active;
  logic       ctrl_unused;
  seq_state_e state;

  // Only the enable bit is decoded
  assign ctrl_unused = &{1'b0, ctrl_word};

  seq_en_filter #(
    .FILT_CYC (FILT_CYC)
  ) u_filter (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   (ctrl_word[EN_BIT]),
    .filt  (en_f)
  );

  seq_mute_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_f         (en_f),
    .sweep_done   (sweep_done),
    .slow_settle  (slow_settle),
    .rate_change  (rate_change),
    .state        (state),
    .sweep_clr    (sweep_clr),
    .sweep_active (sweep_active)
  );

  seq_clear_sweep #(
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W)
  ) u_sweep (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (sweep_clr),
    .active   (sweep_active),
    .wr_ready (fifo_wr_ready),
    .wr_valid (fifo_wr_valid),
    .wr_addr  (fifo_wr_addr),
    .wr_data  (fifo_wr_data),
    .done     (sweep_done)
  );

  assign busy      = sweep_active;
  assign out_en    = (state != ST_OFF);
  assign mute_out  = (state == ST_RUN);
  assign path_mute = (state != ST_RUN);

endmodule

// File: rtl/conv_mute_seq_chk.sv
module conv_mute_seq_chk #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 24,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rate_change,
  input logic              slow_settle,
  input logic              fifo_wr_valid,
  input logic              fifo_wr_ready,
  input logic [ADDR_W-1:0] fifo_wr_addr,
  input logic [DATA_W-1:0] fifo_wr_data,
  input logic              busy,
  input logic              mute_out,
  input logic              out_en,
  input logic              path_mute
);

  localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(DEPTH - 1);

  // R5: a stalled offer keeps its address until accepted or withdrawn
  a_r5_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_valid && !fifo_wr_ready |=> !fifo_wr_valid || $stable(fifo_wr_addr));

  // R5: an accepted write moves to the next location
  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_valid && fifo_wr_ready && (fifo_wr_addr != ADDR_LAST)
    |=> !fifo_wr_valid || (fifo_wr_addr == ADDR_W'($past(fifo_wr_addr) + 1'b1)));

  // R5: clearing writes carry zero
  a_r5_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_valid |-> (fifo_wr_data == '0));

  // R4: every sweep begins at location 0
  a_r4_sweep_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (fifo_wr_addr == '0));

  // R7: mute-out rises only after slow settling was reported
  a_r7_rise_needs_slow: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mute_out) |-> $past(slow_settle));

  // R8: a rate change drops mute-out on the next edge
  a_r8_rate_drops_mute: assert property (@(posedge clk) disable iff (!rst_n)
    rate_change |=> !mute_out);

  // R9: disabled outputs mean no mute-out and no sweep
  a_r9_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> !mute_out && !busy && !fifo_wr_valid);

  // R10: the sample path is muted whenever mute-out is low
  a_r10_path_mute: assert property (@(posedge clk) disable iff (!rst_n)
    !mute_out |-> path_mute);

endmodule

bind conv_mute_seq conv_mute_seq_chk #(
  .DEPTH  (DEPTH),
  .DATA_W (DATA_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rate_change   (rate_change),
  .slow_settle   (slow_settle),
  .fifo_wr_valid (fifo_wr_valid),
  .fifo_wr_ready (fifo_wr_ready),
  .fifo_wr_addr  (fifo_wr_addr),
  .fifo_wr_data  (fifo_wr_data),
  .busy          (busy),
  .mute_out      (mute_out),
  .out_en        (out_en),
  .path_mute     (path_mute)
);

// File: tb/test_conv_mute_seq.sv
module test_conv_mute_seq;

  localparam int DEPTH  = 4;
  localparam int DATA_W = 8;
  localparam int ADDR_W = $clog2(DEPTH);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [31:0]       ctrl_word = '0;
  logic              rate_change = 1'b0;
  logic              slow_settle = 1'b0;
  logic              fifo_wr_ready = 1'b0;
  logic              fifo_wr_valid;
  logic [ADDR_W-1:0] fifo_wr_addr;
  logic [DATA_W-1:0] fifo_wr_data;
  logic              busy, mute_out, out_en, path_mute;

  int applied = 0;
  int errors  = 0;
  int cycles  = 0;

  always #4 clk = ~clk;

  conv_mute_seq #(
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W)
  ) i_conv_mute_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctrl_word     (ctrl_word),
    .rate_change   (rate_change),
    .slow_settle   (slow_settle),
    .fifo_wr_valid (fifo_wr_valid),
    .fifo_wr_ready (fifo_wr_ready),
    .fifo_wr_addr  (fifo_wr_addr),
    .fifo_wr_data  (fifo_wr_data),
    .busy          (busy),
    .mute_out      (mute_out),
    .out_en        (out_en),
    .path_mute     (path_mute)
  );

  typedef struct packed {
    logic [31:0] ctrl;
    logic        rdy;
    logic        slow;
    logic        rate;
    logic [3:0]  hold;
    logic        oe;
    logic        mute;
    logic        bsy;
    logic [1:0]  addr;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{32'h0000_0000, 1'b0, 1'b0, 1'b0, 4'd3, 1'b0, 1'b0, 1'b0, 2'd0, 4'd1 },  // R1 idle
    '{32'h8000_0000, 1'b0, 1'b0, 1'b0, 4'd4, 1'b0, 1'b0, 1'b0, 2'd0, 4'd3 },  // R3 short high ignored
    '{32'h7FFF_FFFF, 1'b0, 1'b0, 1'b0, 4'd7, 1'b0, 1'b0, 1'b0, 2'd0, 4'd2 },  // R2 other bits ignored
    '{32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 4'd6, 1'b1, 1'b0, 1'b1, 2'd0, 4'd4 },  // R4 enable accepted
    '{32'h8000_0000, 1'b0, 1'b0, 1'b0, 4'd3, 1'b1, 1'b0, 1'b1, 2'd0, 4'd5 },  // R5 stall holds
    '{32'h8000_0000, 1'b1, 1'b0, 1'b0, 4'd2, 1'b1, 1'b0, 1'b1, 2'd2, 4'd5 },  // R5 advance
    '{32'h8000_0000, 1'b1, 1'b0, 1'b0, 4'd2, 1'b1, 1'b0, 1'b0, 2'd0, 4'd6 },  // R6 sweep ends
    '{32'h8000_0000, 1'b1, 1'b0, 1'b0, 4'd5, 1'b1, 1'b0, 1'b0, 2'd0, 4'd7 },  // R7 fast settling
    '{32'h8000_0000, 1'b1, 1'b1, 1'b0, 4'd1, 1'b1, 1'b1, 1'b0, 2'd0, 4'd7 },  // R7 slow settling
    '{32'h8000_0000, 1'b1, 1'b1, 1'b1, 4'd1, 1'b1, 1'b0, 1'b0, 2'd0, 4'd8 },  // R8 rate change
    '{32'h8000_0000, 1'b1, 1'b1, 1'b0, 4'd1, 1'b1, 1'b1, 1'b0, 2'd0, 4'd8 },  // R8 recovers
    '{32'h0000_0000, 1'b1, 1'b1, 1'b0, 4'd4, 1'b1, 1'b1, 1'b0, 2'd0, 4'd3 },  // R3 short low ignored
    '{32'h8000_0000, 1'b1, 1'b1, 1'b0, 4'd3, 1'b1, 1'b1, 1'b0, 2'd0, 4'd3 },  // R3 count restarts
    '{32'h0000_0000, 1'b1, 1'b1, 1'b0, 4'd6, 1'b0, 1'b0, 1'b0, 2'd0, 4'd9 },  // R9 disable
    '{32'h8000_0000, 1'b0, 1'b0, 1'b0, 4'd6, 1'b1, 1'b0, 1'b1, 2'd0, 4'd4 },  // R4 second start
    '{32'h8000_0000, 1'b1, 1'b0, 1'b0, 4'd1, 1'b1, 1'b0, 1'b1, 2'd1, 4'd5 },  // R5 one write
    '{32'h0000_0000, 1'b0, 1'b0, 1'b0, 4'd6, 1'b0, 1'b0, 1'b0, 2'd0, 4'd9 },  // R9 abort mid-sweep
    '{32'h8000_0000, 1'b1, 1'b0, 1'b0, 4'd6, 1'b1, 1'b0, 1'b1, 2'd0, 4'd9 },  // R9 restart at 0
    '{32'h8000_0000, 1'b1, 1'b0, 1'b0, 4'd4, 1'b1, 1'b0, 1'b0, 2'd0, 4'd6 },  // R6 full sweep
    '{32'h8000_0000, 1'b1, 1'b0, 1'b1, 4'd1, 1'b1, 1'b0, 1'b0, 2'd0, 4'd8 },  // R8 pulse while muted
    '{32'h8000_0000, 1'b1, 1'b1, 1'b0, 4'd1, 1'b1, 1'b1, 1'b0, 2'd0, 4'd7 }   // R7 rise
  };

  task automatic check_outputs(input int req, input logic e_oe, input logic e_mute,
                               input logic e_busy, input logic [1:0] e_addr, input int idx);
    logic bad;
    bad = (out_en !== e_oe) || (mute_out !== e_mute) || (busy !== e_busy) ||
          (fifo_wr_valid !== e_busy) || (path_mute !== !e_mute) ||
          (e_busy && (fifo_wr_addr !== ADDR_W'(e_addr))) ||
          (e_busy && (fifo_wr_data !== '0));
    applied++;
    if (bad) begin
      errors++;
      $display("FAIL R%0d step %0d: oe=%b mute=%b busy=%b valid=%b pm=%b addr=%0d data=%0h expected oe=%b mute=%b busy=%b valid=%b pm=%b addr=%0d data=0",
               req, idx, out_en, mute_out, busy, fifo_wr_valid, path_mute, fifo_wr_addr,
               fifo_wr_data, e_oe, e_mute, e_busy, e_busy, !e_mute, e_addr);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: run did not end, cycles=%0d expected below 20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_outputs(1, 1'b0, 1'b0, 1'b0, 2'd0, -1);  // R1 under reset
    rst_n = 1'b1;
    @(negedge clk);
    check_outputs(1, 1'b0, 1'b0, 1'b0, 2'd0, -2);  // R1 after release

    for (int i = 0; i < NV; i++) begin
      ctrl_word     = VEC[i].ctrl;
      fifo_wr_ready = VEC[i].rdy;
      slow_settle   = VEC[i].slow;
      rate_change   = VEC[i].rate;
      for (int k = 0; k < int'(VEC[i].hold); k++) begin
        @(posedge clk);
        @(negedge clk);
        rate_change = 1'b0;
      end
      check_outputs(int'(VEC[i].req), VEC[i].oe, VEC[i].mute, VEC[i].bsy, VEC[i].addr, i);
    end

    // R1: reset in the running phase returns everything to idle
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check_outputs(1, 1'b0, 1'b0, 1'b0, 2'd0, 100);
    rst_n = 1'b1;
    // R3: enable still high, accepted after 5 edges, sweep on the 6th (R4)
    repeat (5) begin
      @(posedge clk);
      @(negedge clk);
    end
    check_outputs(3, 1'b0, 1'b0, 1'b0, 2'd0, 101);
    @(posedge clk);
    @(negedge clk);
    check_outputs(4, 1'b1, 1'b0, 1'b1, 2'd0, 102);

    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end

endmodule